// File: doc/BRIEF.md
# Per-block security address gate

The gate sits between a bus master and a memory and filters every request by security world. The protected region is cut into equal blocks, and a bitmap holds one bit per block. The bit gives the block to exactly one world. A bit of 0 makes the block secure-only and a bit of 1 makes it non-secure-only. A request that matches its block's world goes to the memory unchanged, and the memory's reply comes back unchanged. A request that does not match is consumed inside the gate. It never reaches the memory, it reads as zero, and it is answered one cycle after acceptance. The reply is an error or OK, chosen by a control input.

The first rejected request after the fault status has been cleared records fault details: the full address, the requester ID, the effective world and the block's bitmap bit. It also raises the status. While the status stays raised, later rejections are still consumed but leave the recorded details alone. A one-cycle clear pulse drops the status.

The bitmap is loaded 32 bits at a time through a simple word-write port. Register decoding and the memory itself are outside this block.

The block size is a power of two of at least 32 bytes. The protected region is a whole number of blocks.

Top module: `sec_block_gate`

## Requirements
- R1: The block number of a request is `up_addr >> BLOCK_LG`. Bitmap word `w` (written through `tbl_idx = w`, `tbl_wdata`) bit `i` governs block `32*w + i`.
- R2: A request passes only when its effective world matches its block's bit. A bit of 1 admits only non-secure requests (`up_nonsec = 1`) and a bit of 0 admits only secure ones.
- R3: A request with `up_attr_unspec = 1` is treated as secure whatever `up_nonsec` says.
- R4: After reset the bitmap is all zero, so every block is secure-only. `irq_stat`, `info_addr` and `info_detail` are 0 and `dn_valid` is low.
- R5: A passing request is presented downstream with the same address, write flag, write data, world flag and requester ID. The downstream reply (data, error) is returned upstream unchanged.
- R6: A rejected request never raises `dn_valid` and has no effect on the memory. It is accepted, and its reply appears on the upstream response one cycle later with all-zero read data.
- R7: The reply to a rejected request has `up_rsp_err` equal to `cfg_err_resp` as sampled in the acceptance cycle. Passing replies carry the downstream error flag.
- R8: A rejection accepted while `irq_stat` is 0 sets `irq_stat`. It loads `info_addr` with the full request address and `info_detail` with: requester ID in bits 15:0, effective non-secure flag in bit 16, and the block's bitmap bit in bit 17. All other bits of `info_detail` are 0.
- R9: While `irq_stat` is 1, further rejections leave `info_addr` and `info_detail` unchanged. A pulse on `irq_clear` with no rejection in that cycle clears `irq_stat`.
- R10: When `irq_clear` and an accepted rejection fall in the same cycle, the rejection wins: `irq_stat` stays 1 and the new details are captured.
- R11: A rejected request is not accepted while any passed request still awaits its downstream reply, so replies return in request order and never collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_addr | input | ADDR_W | Request byte address within the region |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DATA_W | Write data |
| up_nonsec | input | 1 | Request is non-secure |
| up_attr_unspec | input | 1 | Security attribute unspecified (treated secure) |
| up_master | input | 16 | Requester ID |
| up_rsp_valid | output | 1 | Upstream reply valid |
| up_rsp_rdata | output | DATA_W | Reply read data |
| up_rsp_err | output | 1 | Reply carries an error |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_nonsec | output | 1 | Forwarded world flag |
| dn_master | output | 16 | Forwarded requester ID |
| dn_rsp_valid | input | 1 | Downstream reply valid |
| dn_rsp_rdata | input | DATA_W | Downstream reply data |
| dn_rsp_err | input | 1 | Downstream reply error |
| tbl_we | input | 1 | Bitmap word write strobe |
| tbl_idx | input | WIW | Bitmap word index |
| tbl_wdata | input | 32 | Bitmap word value |
| cfg_err_resp | input | 1 | Rejections reply with an error |
| irq_clear | input | 1 | Clear pulse for the fault status |
| irq_stat | output | 1 | Fault status |
| info_addr | output | 32 | Captured fault address |
| info_detail | output | 32 | Captured requester ID, world flag and bitmap bit |

## Verification
The hardest case to reach from the ports is a rejected request that arrives while a passed request is still in flight downstream. The gate must hold the rejection back until the earlier reply has returned. To create it, the bench stretches its memory model's reply latency to several cycles. It then places a mismatching request on the upstream port right after a matching one, and checks that `up_ready` stays low until the first reply has come back. The capture race is created by asserting the clear pulse in the exact cycle a rejection is accepted. The bench then checks that the status stays set and the details switch to the new address.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam int MASTER_W     = 16;
  localparam int DETAIL_NS    = 16;
  localparam int DETAIL_CFG   = 17;
  localparam int TBL_WORD_W   = 32;

  function automatic logic [31:0] pack_detail(input logic [MASTER_W-1:0] master,
                                              input logic ns, input logic cfg);
    logic [31:0] d;
    d = '0;
    d[MASTER_W-1:0] = master;
    d[DETAIL_NS]    = ns;
    d[DETAIL_CFG]   = cfg;
    return d;
  endfunction
endpackage

// File: rtl/sgate_table.sv
module sgate_table
  import sgate_pkg::*;
#(
  parameter int NBLK = 64,
  parameter int NWORDS = (NBLK + TBL_WORD_W - 1) / TBL_WORD_W,
  parameter int WIW = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  parameter int BIW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WIW-1:0]        wr_idx,
  input  logic [TBL_WORD_W-1:0] wr_data,
  input  logic [BIW-1:0]        look_blk,
  output logic                  look_ns
);
  logic [NWORDS*TBL_WORD_W-1:0] bits;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        bits[w*TBL_WORD_W +: TBL_WORD_W] <= '0;
      else if (wr_en && wr_idx == WIW'(w))
        bits[w*TBL_WORD_W +: TBL_WORD_W] <= wr_data;
    end
  end

  assign look_ns = bits[look_blk];
endmodule

// File: rtl/sgate_ctrl.sv
module sgate_ctrl #(
  parameter int MAX_OUT = 4,
  parameter int OCW = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic up_valid,
  input  logic allow,
  input  logic dn_ready,
  input  logic dn_rsp_valid,
  input  logic cfg_err,
  output logic up_ready,
  output logic dn_valid,
  output logic blk_acc,
  output logic blk_rsp_valid,
  output logic blk_rsp_err
);
  logic [OCW-1:0] outst;
  logic room, idle, inc, dec;

  assign room     = (outst != OCW'(MAX_OUT));
  assign idle     = (outst == '0);
  assign dn_valid = up_valid & allow & room;
  assign up_ready = allow ? (dn_ready & room) : idle;
  assign blk_acc  = up_valid & ~allow & idle & ~rst;
  assign inc      = dn_valid & dn_ready;
  assign dec      = dn_rsp_valid & ~idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst         <= '0;
      blk_rsp_valid <= 1'b0;
      blk_rsp_err   <= 1'b0;
    end else begin
      if (inc && !dec)      outst <= outst + 1'b1;
      else if (dec && !inc) outst <= outst - 1'b1;
      blk_rsp_valid <= blk_acc;
      blk_rsp_err   <= blk_acc & cfg_err;
    end
  end
endmodule

// File: rtl/sgate_fault.sv
module sgate_fault
  import sgate_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                blk_acc,
  input  logic                clr,
  input  logic [AW-1:0]       addr,
  input  logic [MASTER_W-1:0] master,
  input  logic                ns,
  input  logic                cfg,
  output logic                stat,
  output logic [31:0]         info_addr,
  output logic [31:0]         info_detail
);
  logic capture;
  assign capture = blk_acc & (~stat | clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat        <= 1'b0;
      info_addr   <= '0;
      info_detail <= '0;
    end else begin
      if (blk_acc)  stat <= 1'b1;
      else if (clr) stat <= 1'b0;
      if (capture) begin
        info_addr   <= 32'(addr);
        info_detail <= pack_detail(master, ns, cfg);
      end
    end
  end
endmodule

// File: rtl/sec_block_gate.sv
module sec_block_gate
  import sgate_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BLOCK_LG = 8,
  parameter int DATA_W   = 32,
  parameter int MAX_OUT  = 4,
  parameter int NBLK     = 1 << (ADDR_W - BLOCK_LG),
  parameter int NWORDS   = (NBLK + TBL_WORD_W - 1) / TBL_WORD_W,
  parameter int WIW      = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  up_valid,
  output logic                  up_ready,
  input  logic [ADDR_W-1:0]     up_addr,
  input  logic                  up_write,
  input  logic [DATA_W-1:0]     up_wdata,
  input  logic                  up_nonsec,
  input  logic                  up_attr_unspec,
  input  logic [MASTER_W-1:0]   up_master,
  output logic                  up_rsp_valid,
  output logic [DATA_W-1:0]     up_rsp_rdata,
  output logic                  up_rsp_err,
  output logic                  dn_valid,
  input  logic                  dn_ready,
  output logic [ADDR_W-1:0]     dn_addr,
  output logic                  dn_write,
  output logic [DATA_W-1:0]     dn_wdata,
  output logic                  dn_nonsec,
  output logic [MASTER_W-1:0]   dn_master,
  input  logic                  dn_rsp_valid,
  input  logic [DATA_W-1:0]     dn_rsp_rdata,
  input  logic                  dn_rsp_err,
  input  logic                  tbl_we,
  input  logic [WIW-1:0]        tbl_idx,
  input  logic [TBL_WORD_W-1:0] tbl_wdata,
  input  logic                  cfg_err_resp,
  input  logic                  irq_clear,
  output logic                  irq_stat,
  output logic [31:0]           info_addr,
  output logic [31:0]           info_detail
);
  localparam int BIW = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic           world_ns, blk_ns, allow, blk_acc;
  logic           blk_rsp_valid, blk_rsp_err;
  logic [BIW-1:0] blk_num;

  assign world_ns = up_nonsec & ~up_attr_unspec;
  assign blk_num  = BIW'(up_addr >> BLOCK_LG);
  assign allow    = (blk_ns == world_ns);

  sgate_table #(.NBLK(NBLK), .NWORDS(NWORDS), .WIW(WIW), .BIW(BIW)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
    .look_blk(blk_num), .look_ns(blk_ns)
  );

  sgate_ctrl #(.MAX_OUT(MAX_OUT)) u_ctrl (
    .clk(clk), .rst(rst), .up_valid(up_valid), .allow(allow), .dn_ready(dn_ready),
    .dn_rsp_valid(dn_rsp_valid), .cfg_err(cfg_err_resp), .up_ready(up_ready),
    .dn_valid(dn_valid), .blk_acc(blk_acc), .blk_rsp_valid(blk_rsp_valid),
    .blk_rsp_err(blk_rsp_err)
  );

  sgate_fault #(.AW(ADDR_W)) u_fault (
    .clk(clk), .rst(rst), .blk_acc(blk_acc), .clr(irq_clear), .addr(up_addr),
    .master(up_master), .ns(world_ns), .cfg(blk_ns), .stat(irq_stat),
    .info_addr(info_addr), .info_detail(info_detail)
  );

  assign dn_addr   = up_addr;
  assign dn_write  = up_write;
  assign dn_wdata  = up_wdata;
  assign dn_nonsec = up_nonsec;
  assign dn_master = up_master;

  assign up_rsp_valid = dn_rsp_valid | blk_rsp_valid;
  assign up_rsp_rdata = blk_rsp_valid ? '0 : dn_rsp_rdata;
  assign up_rsp_err   = blk_rsp_valid ? blk_rsp_err : dn_rsp_err;
endmodule

// File: rtl/sec_block_gate_chk.sv
module sec_block_gate_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_acc,
  input logic              dn_valid,
  input logic              dn_rsp_valid,
  input logic              up_rsp_valid,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              cfg_err_resp,
  input logic [ADDR_W-1:0] up_addr,
  input logic              irq_clear,
  input logic              irq_stat,
  input logic [31:0]       info_addr,
  input logic [31:0]       info_detail
);
  // R6
  a_r6_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    blk_acc |-> !dn_valid);
  // R6
  a_r6_zero_reply: assert property (@(posedge clk) disable iff (rst)
    blk_acc |=> (up_rsp_valid && up_rsp_rdata == '0));
  // R7
  a_r7_err_follows_cfg: assert property (@(posedge clk) disable iff (rst)
    blk_acc |=> (up_rsp_err == $past(cfg_err_resp)));
  // R8
  a_r8_first_capture: assert property (@(posedge clk) disable iff (rst)
    (blk_acc && !irq_stat) |=> (irq_stat && info_addr == 32'($past(up_addr))));
  // R9
  a_r9_hold_info: assert property (@(posedge clk) disable iff (rst)
    (irq_stat && !irq_clear) |=> (irq_stat && $stable(info_addr) && $stable(info_detail)));
  // R10
  a_r10_fault_wins: assert property (@(posedge clk) disable iff (rst)
    (blk_acc && irq_clear) |=> irq_stat);
  // R11
  a_r11_no_collision: assert property (@(posedge clk) disable iff (rst)
    blk_acc |-> !dn_rsp_valid);
endmodule

bind sec_block_gate sec_block_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .blk_acc(blk_acc), .dn_valid(dn_valid),
  .dn_rsp_valid(dn_rsp_valid), .up_rsp_valid(up_rsp_valid),
  .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err), .cfg_err_resp(cfg_err_resp),
  .up_addr(up_addr), .irq_clear(irq_clear), .irq_stat(irq_stat),
  .info_addr(info_addr), .info_detail(info_detail)
);

// File: tb/sec_block_gate_bench.sv
module sec_block_gate_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        up_valid = 0, up_write = 0, up_nonsec = 0, up_attr_unspec = 0;
  logic [13:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic [15:0] up_master = '0;
  logic        up_ready, up_rsp_valid, up_rsp_err;
  logic [31:0] up_rsp_rdata;
  logic        dn_valid, dn_write, dn_nonsec;
  logic        dn_ready = 1'b1;
  logic [13:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [15:0] dn_master;
  logic        dn_rsp_valid;
  logic [31:0] dn_rsp_rdata;
  logic        tbl_we = 0, cfg_err_resp = 0, irq_clear = 0;
  logic [0:0]  tbl_idx = '0;
  logic [31:0] tbl_wdata = '0;
  logic        irq_stat;
  logic [31:0] info_addr, info_detail;

  sec_block_gate u_sec_block_gate (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_write(up_write), .up_wdata(up_wdata), .up_nonsec(up_nonsec),
    .up_attr_unspec(up_attr_unspec), .up_master(up_master), .up_rsp_valid(up_rsp_valid),
    .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write), .dn_wdata(dn_wdata),
    .dn_nonsec(dn_nonsec), .dn_master(dn_master), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(1'b0), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .cfg_err_resp(cfg_err_resp), .irq_clear(irq_clear),
    .irq_stat(irq_stat), .info_addr(info_addr), .info_detail(info_detail)
  );

  // Downstream memory model: one reply, lat_cfg extra cycles after acceptance.
  int          lat_cfg = 0;
  int          pend_cnt;
  logic        pend;
  logic [13:0] m_addr;
  int          wr_count;
  logic [31:0] last_wdata;
  logic [15:0] last_master;
  logic        last_ns;
  assign dn_rsp_valid = pend && pend_cnt == 0;
  assign dn_rsp_rdata = {18'h0, m_addr} ^ 32'hC3C3_0000;

  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; pend_cnt <= 0; m_addr <= '0; wr_count <= 0;
      last_wdata <= '0; last_master <= '0; last_ns <= 1'b0;
    end else begin
      if (dn_rsp_valid) pend <= 1'b0;
      if (dn_valid && dn_ready) begin
        pend <= 1'b1; pend_cnt <= lat_cfg; m_addr <= dn_addr;
        last_master <= dn_master; last_ns <= dn_nonsec;
        if (dn_write) begin wr_count <= wr_count + 1; last_wdata <= dn_wdata; end
      end else if (pend && pend_cnt != 0) pend_cnt <= pend_cnt - 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  function automatic logic [13:0] ba(input int blk, input int off);
    return 14'(blk * 256 + off);
  endfunction

  function automatic logic [31:0] model_rd(input logic [13:0] a);
    return {18'h0, a} ^ 32'hC3C3_0000;
  endfunction

  task automatic xfer(input logic [13:0] a, input logic wr, input logic [31:0] wd,
                      input logic ns, input logic un, input logic [15:0] m, input logic clr,
                      output logic [31:0] rd, output logic er, output logic fwd, output int lat);
    @(negedge clk);
    up_valid = 1; up_addr = a; up_write = wr; up_wdata = wd;
    up_nonsec = ns; up_attr_unspec = un; up_master = m; irq_clear = clr;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
    fwd = dn_valid;
    @(posedge clk);
    @(negedge clk);
    up_valid = 0; irq_clear = 0; lat = 1;
    while (!up_rsp_valid) begin @(negedge clk); lat++; end
    rd = up_rsp_rdata; er = up_rsp_err;
  endtask

  task automatic tbl_write(input logic idx, input logic [31:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_idx = idx; tbl_wdata = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    irq_clear = 1;
    @(negedge clk);
    irq_clear = 0;
  endtask

  logic [31:0] rd; logic er, fwd; int lat;

  task automatic t_reset();
    check("R4 irq_stat", 32'(irq_stat), 0);
    check("R4 info_addr", info_addr, 0);
    check("R4 info_detail", info_detail, 0);
    check("R4 dn_valid idle", 32'(dn_valid), 0);
    xfer(ba(0, 4), 0, 0, 0, 0, 16'h1, 0, rd, er, fwd, lat);
    check("R4 secure to block 0 passes", 32'(fwd), 1);
    xfer(ba(63, 8), 0, 0, 0, 0, 16'h1, 0, rd, er, fwd, lat);
    check("R4 secure to block 63 passes", 32'(fwd), 1);
    xfer(ba(63, 8), 0, 0, 1, 0, 16'h1, 0, rd, er, fwd, lat);
    check("R4 non-secure to block 63 rejected", 32'(fwd), 0);
    pulse_clear();
  endtask

  task automatic t_map();
    tbl_write(1'b1, 32'h0000_0020);
    xfer(ba(37, 16), 0, 0, 1, 0, 16'h2, 0, rd, er, fwd, lat);
    check("R1 word1 bit5 gives block 37 to non-secure", 32'(fwd), 1);
    xfer(ba(36, 16), 0, 0, 0, 0, 16'h2, 0, rd, er, fwd, lat);
    check("R1 block 36 stays secure", 32'(fwd), 1);
    xfer(ba(5, 16), 0, 0, 0, 0, 16'h2, 0, rd, er, fwd, lat);
    check("R1 word0 bit5 block 5 stays secure", 32'(fwd), 1);
  endtask

  task automatic t_world();
    tbl_write(1'b0, 32'h0000_0004);
    xfer(ba(2, 0), 0, 0, 1, 0, 16'h3, 0, rd, er, fwd, lat);
    check("R2 non-secure to NS block passes", 32'(fwd), 1);
    xfer(ba(2, 0), 0, 0, 0, 0, 16'h3, 0, rd, er, fwd, lat);
    check("R2 secure to NS block rejected", 32'(fwd), 0);
    xfer(ba(3, 0), 0, 0, 1, 0, 16'h3, 0, rd, er, fwd, lat);
    check("R2 non-secure to secure block rejected", 32'(fwd), 0);
    pulse_clear();
  endtask

  task automatic t_unspec();
    xfer(ba(3, 0), 0, 0, 1, 1, 16'h4, 0, rd, er, fwd, lat);
    check("R3 unspecified to secure block passes", 32'(fwd), 1);
    xfer(ba(2, 0), 0, 0, 1, 1, 16'h4, 0, rd, er, fwd, lat);
    check("R3 unspecified to NS block rejected", 32'(fwd), 0);
    pulse_clear();
  endtask

  task automatic t_forward();
    int w0;
    w0 = wr_count;
    xfer(ba(37, 12), 1, 32'hDEAD_BEEF, 1, 0, 16'hABCD, 0, rd, er, fwd, lat);
    check("R5 write reaches memory", 32'(wr_count - w0), 1);
    check("R5 write data unchanged", last_wdata, 32'hDEAD_BEEF);
    check("R5 requester ID unchanged", 32'(last_master), 32'hABCD);
    check("R5 world flag unchanged", 32'(last_ns), 1);
    xfer(ba(10, 20), 0, 0, 0, 0, 16'h5, 0, rd, er, fwd, lat);
    check("R5 read data returned", rd, model_rd(ba(10, 20)));
    check("R5 read error flag", 32'(er), 0);
  endtask

  task automatic t_reject();
    int w0;
    w0 = wr_count;
    cfg_err_resp = 0;
    xfer(ba(20, 0), 0, 0, 1, 0, 16'h6, 0, rd, er, fwd, lat);
    check("R6 rejected read data zero", rd, 0);
    check("R6 rejected reply one cycle later", 32'(lat), 1);
    check("R7 OK reply when error bit clear", 32'(er), 0);
    cfg_err_resp = 1;
    xfer(ba(20, 4), 1, 32'h1234_5678, 1, 0, 16'h6, 0, rd, er, fwd, lat);
    check("R7 error reply when error bit set", 32'(er), 1);
    check("R6 rejected write not forwarded", 32'(wr_count - w0), 0);
    xfer(ba(21, 0), 0, 0, 0, 0, 16'h6, 0, rd, er, fwd, lat);
    check("R7 passing reply keeps downstream OK", 32'(er), 0);
    cfg_err_resp = 0;
    pulse_clear();
  endtask

  task automatic t_capture();
    check("R9 status cleared by pulse", 32'(irq_stat), 0);
    xfer(ba(5, 8'h3C), 0, 0, 1, 0, 16'h1234, 0, rd, er, fwd, lat);
    check("R8 status set", 32'(irq_stat), 1);
    check("R8 address captured", info_addr, 32'(ba(5, 8'h3C)));
    check("R8 detail captured", info_detail, 32'h0001_1234);
    xfer(ba(2, 8), 0, 0, 0, 0, 16'h0077, 0, rd, er, fwd, lat);
    check("R9 later fault leaves address", info_addr, 32'(ba(5, 8'h3C)));
    check("R9 later fault leaves detail", info_detail, 32'h0001_1234);
    pulse_clear();
    check("R9 clear drops status", 32'(irq_stat), 0);
    xfer(ba(2, 8), 0, 0, 0, 0, 16'h0077, 0, rd, er, fwd, lat);
    check("R8 recapture address", info_addr, 32'(ba(2, 8)));
    check("R8 recapture detail with table bit", info_detail, 32'h0002_0077);
  endtask

  task automatic t_race();
    xfer(ba(40, 0), 0, 0, 1, 0, 16'h0099, 1, rd, er, fwd, lat);
    check("R10 status stays set", 32'(irq_stat), 1);
    check("R10 new address captured", info_addr, 32'(ba(40, 0)));
    check("R10 new detail captured", info_detail, 32'h0001_0099);
    pulse_clear();
  endtask

  task automatic t_order();
    bit got_pass;
    bit ready_early;
    int n;
    lat_cfg = 3;
    got_pass = 0; ready_early = 0;
    @(negedge clk);
    up_valid = 1; up_addr = ba(8, 0); up_write = 0; up_nonsec = 0; up_attr_unspec = 0;
    #1;
    check("R11 pass accepted at once", 32'(up_ready), 1);
    @(posedge clk);
    @(negedge clk);
    up_addr = ba(8, 4); up_nonsec = 1;
    #1;
    n = 0;
    while (!up_ready && n < 20) begin
      if (up_rsp_valid) begin
        got_pass = 1;
        check("R11 earlier reply data", up_rsp_rdata, model_rd(ba(8, 0)));
      end
      @(negedge clk); #1; n++;
    end
    if (!got_pass) ready_early = 1;
    check("R11 rejection held until earlier reply", 32'(ready_early), 0);
    @(posedge clk);
    @(negedge clk);
    up_valid = 0;
    check("R11 rejected reply follows", 32'(up_rsp_valid && up_rsp_rdata == 0), 1);
    lat_cfg = 0;
    pulse_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_map();
    t_world();
    t_unspec();
    t_forward();
    t_reject();
    t_capture();
    t_race();
    t_order();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule